// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps a device in reset after power-on until the supply and the primary clock can be trusted. A power-on-reset input (`por`, active high) asynchronously clears every counter, flag and state. Once it falls, a set of delays runs in the domain of a free-running internal timebase clock (`tmr_clk`). A short ready delay always runs. A longer power-up timer runs only when its enable bit is set. The oscillator-mode code selects further delays on top of these.

In the crystal modes, a counter clocked by the raw oscillator input counts a fixed number of oscillator rising edges, 1024 by default. Its done flag crosses into the timebase domain through a two-flop synchronizer. Only then may the oscillator clock the core. The high-speed PLL mode adds a timed PLL-lock wait after that count. The external-clock, RC and internal modes skip the oscillator count, so the core clock is enabled at once.

The core clock-enable rises as soon as the oscillator is judged stable. The reset output stays high until every delay that applies has completed. The sequencer moves through these states:

- `ST_IDLE`: held by `por`.
- `ST_OST_WAIT`: crystal modes wait for the synchronized count.
- `ST_PLL_WAIT`: the PLL mode waits for lock.
- `ST_HOLD`: the clock is enabled and the fixed delays are awaited.
- `ST_RUN`: released.

The transitions are:

- `ST_IDLE`→`ST_OST_WAIT` for a crystal mode.
- `ST_IDLE`→`ST_HOLD` otherwise.
- `ST_OST_WAIT`→`ST_PLL_WAIT` when the count is done in PLL mode.
- `ST_OST_WAIT`→`ST_HOLD` when the count is done in any other crystal mode.
- `ST_PLL_WAIT`→`ST_HOLD` when the lock wait is done.
- `ST_HOLD`→`ST_RUN` when the fixed delays are done.
- Any state→`ST_IDLE` on `por`.

Top module: `pur_seq`

## Requirements
- R1: While `por` is high, `rst_out` is 1 and `core_clk_en` is 0.
- R2: Mode codes 0, 1 and 2 (the low-power, standard and high-speed crystal modes) start the oscillator count. `core_clk_en` rises on the second `tmr_clk` edge after the first `tmr_clk` edge that follows the OST_COUNT-th `osc_clk` rising edge after `por` falls.
- R3: Mode codes 4, 5, 6 and 7 (external clock, RC, internal oscillator) run no oscillator count. `core_clk_en` rises on the first `tmr_clk` edge after `por` falls.
- R4: Mode code 3 (high-speed with PLL) behaves as R2 for the clock-enable. It then waits PLL_CYCLES further `tmr_clk` edges in `ST_PLL_WAIT`. It enters `ST_HOLD` on the edge after that wait completes.
- R5: When `pwrt_en` is 1, the power-up timer needs PWRT_CYCLES `tmr_clk` edges after `por` falls before release. When `pwrt_en` is 0, the timer has no effect on the release time.
- R6: The ready delay of READY_CYCLES `tmr_clk` edges starts when `por` falls. It runs in parallel with all other delays in every mode.
- R7: `rst_out` falls on `tmr_clk` edge max(E, F)+1. E is the edge on which `ST_HOLD` is entered: 1 in non-crystal modes. F is max(READY_CYCLES, PWRT_CYCLES when `pwrt_en` is 1).
- R8: Once released, `rst_out` stays 0 and `core_clk_en` stays 1 until the next `por`.
- R9: A new `por` pulse at any time forces R1 immediately and restarts the whole sequence from edge 1.
- R10: `rst_out` is never 0 while `core_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tmr_clk | input | 1 | Free-running internal timebase clock |
| osc_clk | input | 1 | Raw primary oscillator clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| osc_mode | input | 3 | Oscillator-mode code (0 LP, 1 XT, 2 HS, 3 HS+PLL, 4 EXT, 5 RC, 6/7 internal) |
| pwrt_en | input | 1 | Power-up timer enable |
| rst_out | output | 1 | Internal reset, active high |
| core_clk_en | output | 1 | Gate enabling the oscillator to clock the core |

## Verification
Edges are numbered from the first `tmr_clk` edge after `por` falls. The bench records the index of the `tmr_clk` edge that follows the OST_COUNT-th oscillator edge by counting both of its own clocks, not by reading the design. From that index, the mode and `pwrt_en`, it computes the exact edge on which `core_clk_en` must rise (R2–R4): one synchronizer edge plus the state update. It also computes the edge on which `rst_out` must fall (R7). Outputs are sampled on the falling edge of `tmr_clk`, so each result is compared in the half cycle after the edge that produced it. The oscillator and timebase periods are chosen so that their edges never coincide.

// File: rtl/pur_pkg.sv
`timescale 1ns/1ps
package pur_pkg;

    typedef enum logic [2:0] {
        MODE_LP    = 3'd0,
        MODE_XT    = 3'd1,
        MODE_HS    = 3'd2,
        MODE_HSPLL = 3'd3,
        MODE_EXT   = 3'd4,
        MODE_RC    = 3'd5,
        MODE_INT   = 3'd6,
        MODE_INT2  = 3'd7
    } osc_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_OST_WAIT = 3'd1,
        ST_PLL_WAIT = 3'd2,
        ST_HOLD     = 3'd3,
        ST_RUN      = 3'd4
    } seq_state_e;

    // Crystal-type modes need the oscillator start-up count.
    function automatic logic mode_is_xtal(input logic [2:0] m);
        return (m <= MODE_HSPLL);
    endfunction

    // Only the PLL mode needs the lock wait.
    function automatic logic mode_is_pll(input logic [2:0] m);
        return (m == MODE_HSPLL);
    endfunction

endpackage

// File: rtl/pur_delay_timer.sv
`timescale 1ns/1ps
// Up-counter that raises a sticky done flag after COUNT enabled edges.
module pur_delay_timer #(
    parameter int unsigned COUNT = 16
) (
    input  logic clk,
    input  logic arst,
    input  logic en,
    output logic done
);
    localparam int unsigned CW = (COUNT > 1) ? $clog2(COUNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(COUNT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (en && !done) begin
            if (cnt == LAST) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pur_sync.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer with asynchronous clear.
module pur_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pur_seq_fsm.sv
`timescale 1ns/1ps
module pur_seq_fsm
    import pur_pkg::*;
(
    input  logic       clk,
    input  logic       arst,
    input  logic       xtal,
    input  logic       pll,
    input  logic       pwrt_en,
    input  logic       ost_done_s,
    input  logic       pll_done,
    input  logic       rdy_done,
    input  logic       pwrt_done,
    output seq_state_e state,
    output logic       rst_out,
    output logic       clk_en,
    output logic       pll_run
);
    seq_state_e state_d;
    logic       fixed_ok;

    assign fixed_ok = rdy_done && (pwrt_done || !pwrt_en);

    // Next-state logic.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:     state_d = xtal ? ST_OST_WAIT : ST_HOLD;
            ST_OST_WAIT: if (ost_done_s) state_d = pll ? ST_PLL_WAIT : ST_HOLD;
            ST_PLL_WAIT: if (pll_done)   state_d = ST_HOLD;
            ST_HOLD:     if (fixed_ok)   state_d = ST_RUN;
            ST_RUN:      state_d = ST_RUN;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        rst_out = 1'b1;
        clk_en  = 1'b0;
        pll_run = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_OST_WAIT: ;
            ST_PLL_WAIT: begin clk_en = 1'b1; pll_run = 1'b1; end
            ST_HOLD:     clk_en = 1'b1;
            ST_RUN:      begin clk_en = 1'b1; rst_out = 1'b0; end
            default:     ;
        endcase
    end

endmodule

// File: rtl/pur_seq.sv
`timescale 1ns/1ps
module pur_seq
    import pur_pkg::*;
#(
    parameter int unsigned OST_COUNT    = 1024,
    parameter int unsigned PWRT_CYCLES  = 65536,
    parameter int unsigned PLL_CYCLES   = 2000,
    parameter int unsigned READY_CYCLES = 8,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic       tmr_clk,
    input  logic       osc_clk,
    input  logic       por,
    input  logic [2:0] osc_mode,
    input  logic       pwrt_en,
    output logic       rst_out,
    output logic       core_clk_en
);
    logic       xtal;
    logic       pll;
    logic       ost_done;
    logic       ost_sync;
    logic       pll_done;
    logic       pll_run;
    logic       rdy_done;
    logic       pwrt_done;
    seq_state_e state;

    assign xtal = mode_is_xtal(osc_mode);
    assign pll  = mode_is_pll(osc_mode);

    // Oscillator start-up count, in the raw oscillator domain.
    pur_delay_timer #(.COUNT(OST_COUNT)) u_ost (
        .clk  (osc_clk),
        .arst (por),
        .en   (xtal),
        .done (ost_done)
    );

    pur_sync #(.STAGES(SYNC_STAGES)) u_ost_sync (
        .clk  (tmr_clk),
        .arst (por),
        .d    (ost_done),
        .q    (ost_sync)
    );

    // Fixed delays in the timebase domain.
    pur_delay_timer #(.COUNT(READY_CYCLES)) u_rdy (
        .clk  (tmr_clk),
        .arst (por),
        .en   (1'b1),
        .done (rdy_done)
    );

    pur_delay_timer #(.COUNT(PWRT_CYCLES)) u_pwrt (
        .clk  (tmr_clk),
        .arst (por),
        .en   (pwrt_en),
        .done (pwrt_done)
    );

    pur_delay_timer #(.COUNT(PLL_CYCLES)) u_pll (
        .clk  (tmr_clk),
        .arst (por),
        .en   (pll_run),
        .done (pll_done)
    );

    pur_seq_fsm u_fsm (
        .clk        (tmr_clk),
        .arst       (por),
        .xtal       (xtal),
        .pll        (pll),
        .pwrt_en    (pwrt_en),
        .ost_done_s (ost_sync),
        .pll_done   (pll_done),
        .rdy_done   (rdy_done),
        .pwrt_done  (pwrt_done),
        .state      (state),
        .rst_out    (rst_out),
        .clk_en     (core_clk_en),
        .pll_run    (pll_run)
    );

endmodule

// File: rtl/pur_seq_chk.sv
`timescale 1ns/1ps
module pur_seq_chk (
    input logic       tmr_clk,
    input logic       por,
    input logic [2:0] osc_mode,
    input logic       pwrt_en,
    input logic       rst_out,
    input logic       core_clk_en,
    input logic       rdy_done,
    input logic       pwrt_done,
    input logic       ost_sync,
    input logic       pll_done
);
    AST_HOLD_IN_POR: assert property (@(posedge tmr_clk)
        por |-> (rst_out && !core_clk_en)); // R1

    AST_XTAL_EN_AFTER_OST: assert property (@(posedge tmr_clk) disable iff (por)
        ($rose(core_clk_en) && (osc_mode <= 3'd3)) |-> ost_sync); // R2

    AST_PLL_BEFORE_RELEASE: assert property (@(posedge tmr_clk) disable iff (por)
        ($fell(rst_out) && (osc_mode == 3'd3)) |-> pll_done); // R4

    AST_PWRT_BEFORE_RELEASE: assert property (@(posedge tmr_clk) disable iff (por)
        ($fell(rst_out) && pwrt_en) |-> pwrt_done); // R5

    AST_READY_BEFORE_RELEASE: assert property (@(posedge tmr_clk) disable iff (por)
        $fell(rst_out) |-> rdy_done); // R6

    AST_RELEASE_STICKY: assert property (@(posedge tmr_clk) disable iff (por)
        !rst_out |=> !rst_out); // R8

    AST_CLK_EN_STICKY: assert property (@(posedge tmr_clk) disable iff (por)
        core_clk_en |=> core_clk_en); // R8

    AST_NO_RELEASE_WITHOUT_CLK: assert property (@(posedge tmr_clk) disable iff (por)
        !rst_out |-> core_clk_en); // R10

endmodule

bind pur_seq pur_seq_chk u_chk (
    .tmr_clk     (tmr_clk),
    .por         (por),
    .osc_mode    (osc_mode),
    .pwrt_en     (pwrt_en),
    .rst_out     (rst_out),
    .core_clk_en (core_clk_en),
    .rdy_done    (rdy_done),
    .pwrt_done   (pwrt_done),
    .ost_sync    (ost_sync),
    .pll_done    (pll_done)
);

// File: tb/pur_seq_tb.sv
`timescale 1ns/1ps
module pur_seq_tb;
    localparam int TB_PERIOD = 10;
    localparam int OST_N     = 1024;
    localparam int PWRT_N    = 300;
    localparam int PLL_N     = 200;
    localparam int RDY_N     = 20;

    logic       tmr_clk;
    logic       osc_clk;
    logic       por;
    logic [2:0] osc_mode;
    logic       pwrt_en;
    logic       rst_out;
    logic       core_clk_en;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    int tb_edges;
    int osc_edges;
    int k_ost;
    int en_edge;
    int rel_edge;
    bit sticky_bad;

    pur_seq #(
        .OST_COUNT    (OST_N),
        .PWRT_CYCLES  (PWRT_N),
        .PLL_CYCLES   (PLL_N),
        .READY_CYCLES (RDY_N),
        .SYNC_STAGES  (2)
    ) u_dut (
        .tmr_clk     (tmr_clk),
        .osc_clk     (osc_clk),
        .por         (por),
        .osc_mode    (osc_mode),
        .pwrt_en     (pwrt_en),
        .rst_out     (rst_out),
        .core_clk_en (core_clk_en)
    );

    initial begin
        tmr_clk = 1'b0;
        forever #(TB_PERIOD / 2) tmr_clk = ~tmr_clk;
    end

    // Oscillator edges are offset so they never meet a timebase edge.
    initial begin
        osc_clk = 1'b0;
        #1.3;
        forever #3.5 osc_clk = ~osc_clk;
    end

    always @(posedge tmr_clk) begin
        if (por) tb_edges = 0;
        else     tb_edges = tb_edges + 1;
    end

    always @(posedge osc_clk) begin
        if (por) begin
            osc_edges = 0;
            k_ost     = 0;
        end else begin
            osc_edges = osc_edges + 1;
            if (osc_edges == OST_N) k_ost = tb_edges + 1;
        end
    end

    always @(negedge tmr_clk) begin
        if (por) begin
            en_edge    = -1;
            rel_edge   = -1;
            sticky_bad = 1'b0;
        end else begin
            if (core_clk_en && en_edge < 0) en_edge = tb_edges;
            if (!rst_out && rel_edge < 0)   rel_edge = tb_edges;
            if (rel_edge >= 0 && (rst_out || !core_clk_en)) sticky_bad = 1'b1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int exp_en_edge(input int m, input int ko);
        return (m <= 3) ? ko + 2 : 1;
    endfunction

    function automatic int exp_rel_edge(input int m, input bit pe, input int ko);
        int e;
        int f;
        if (m <= 3) e = ko + 2 + ((m == 3) ? PLL_N + 1 : 0);
        else        e = 1;
        f = imax(RDY_N, pe ? PWRT_N : 0);
        return imax(e, f) + 1;
    endfunction

    task automatic start_por(input int m, input bit pe, input int hold);
        @(negedge tmr_clk);
        osc_mode = 3'(m);
        pwrt_en  = pe;
        por      = 1'b1;
        repeat (hold) @(negedge tmr_clk);
        chk("R1 rst_out in por", int'(rst_out), 1);
        chk("R1 clk_en in por", int'(core_clk_en), 0);
        por = 1'b0;
    endtask

    task automatic run_seq(input int m, input bit pe, input int hold);
        string tag;
        start_por(m, pe, hold);
        for (int i = 0; i < 3000 && rel_edge < 0; i++) @(negedge tmr_clk);
        repeat (8) @(negedge tmr_clk);
        if (m == 3)      tag = "R4";
        else if (m <= 2) tag = "R2";
        else             tag = "R3";
        chk({tag, " clk_en edge"}, en_edge, exp_en_edge(m, k_ost));
        chk({pe ? "R5" : "R6", " R7 release edge"}, rel_edge, exp_rel_edge(m, pe, k_ost));
        chk("R8 R10 sticky after release", int'(sticky_bad), 0);
    endtask

    initial begin
        por      = 1'b1;
        osc_mode = 3'd0;
        pwrt_en  = 1'b0;
        void'($urandom(32'h5eed_2024));

        // Directed: every mode with both timer settings.
        for (int m = 0; m < 8; m++) begin
            run_seq(m, 1'b0, 3);
            run_seq(m, 1'b1, 3);
        end

        // R9: abort a non-crystal sequence after its clock-enable rose.
        start_por(5, 1'b1, 2);
        repeat (100) @(negedge tmr_clk);
        chk("R3 clk_en before abort", int'(core_clk_en), 1);
        por = 1'b1;
        #1;
        chk("R9 rst_out on new por", int'(rst_out), 1);
        chk("R9 clk_en on new por", int'(core_clk_en), 0);
        @(negedge tmr_clk);
        por = 1'b0;
        repeat (4) @(negedge tmr_clk);
        run_seq(5, 1'b1, 2);

        // R9: por after release of a PLL sequence.
        run_seq(3, 1'b0, 4);
        @(negedge tmr_clk);
        por = 1'b1;
        #1;
        chk("R9 rst_out after release", int'(rst_out), 1);
        chk("R9 clk_en after release", int'(core_clk_en), 0);
        @(negedge tmr_clk);

        // Random modes, timer enables and por widths.
        for (int i = 0; i < 12; i++) begin
            run_seq(int'($urandom_range(7, 0)), 1'($urandom_range(1, 0)),
                    int'($urandom_range(6, 1)));
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        finished = 1;
        $finish;
    end

    initial begin
        #(TB_PERIOD * 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule